// File: doc/BRIEF.md
# Carry-Save Sequential Multiplier

This block multiplies two unsigned N-bit operands one multiplier bit per clock, shift-and-add fashion. The running high half of the product is not kept as a single binary word. It is kept as two registers: a sum word and a separate word of saved carries, one bit narrower than the sum. Each step passes the sum, the saved carries and the gated multiplicand through one row of independent full adders. No carry travels along the row, so a step costs about one full-adder delay whatever the width.

The carries produced in a step are latched and folded in on the next step. Before the pair shifts right, the weight-0 sum bit is already exact, and it enters the multiplier/quotient register as the next low product bit. After N steps, one ordinary carry-propagate addition merges the sum and carry words into the final high half.

A one-cycle `start` pulse while idle captures both operands. `done` pulses when the 2N-bit product is available. The product then stays on its port until the next operation is accepted.

Top module: `cs_seq_mult`

## Requirements
- R1: When `done` is high, `product` equals the unsigned product `multiplicand * multiplier` of the operands captured at the accepted start, as a 2N-bit value.
- R2: `done` is high for exactly one cycle. It rises after the (N+1)-th rising clock edge that follows the edge accepting `start`: N step edges and then one resolution edge.
- R3: A `start` seen while an operation is in progress is ignored. The operands are not recaptured, the running result is not disturbed, and the timing of `done` is unchanged.
- R4: Bits `[2N-1:N]` of `product` hold the high half of the product and bits `[N-1:0]` hold the low half. The low half is built in the register that held the multiplier.
- R5: After reset, `product` is zero and `done` is low.
- R6: While idle, `product` keeps its value until the next accepted start. A `start` in the cycle where `done` is high is accepted.
- R7: The operand corner cases give exact products: a zero operand gives 0, an operand of 1 gives the other operand, and all-ones times all-ones gives (2^N-1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins an operation when the block is idle |
| multiplicand | input | N | Operand added on each step whose multiplier bit is 1 |
| multiplier | input | N | Operand scanned from its least significant bit |
| product | output | 2N | High half then low half of the result |
| done | output | 1 | One-cycle pulse marking a valid product |

## Verification
A wrong saved carry, or one folded in at the wrong weight, breaks the invariant that the weight-0 sum bit is exact. The error then shows up in the low half of `product` in the very step it occurs, and it also skews the high half after resolution. It is visible at the `done` pulse, N+1 cycles after start. A broken step counter or state sequence shows as `done` arriving a cycle early or late. In that case the product is also short or over-shifted. A start that leaks through while busy shows as a product of the wrong operands at the first `done`.

// File: rtl/cs_mult_pkg.sv
package cs_mult_pkg;
  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_STEP    = 2'd1,
    PH_RESOLVE = 2'd2
  } phase_t;
endpackage

// File: rtl/cs_adder_row.sv
module cs_adder_row #(
  parameter int W = 8
) (
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W-1:0] in_c,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] cry_o
);
  // one independent full adder per bit, no carry chain between positions
  for (genvar g = 0; g < W; g++) begin : g_fa
    assign sum_o[g] = in_a[g] ^ in_b[g] ^ in_c[g];
    assign cry_o[g] = (in_a[g] & in_b[g]) | (in_a[g] & in_c[g]) | (in_b[g] & in_c[g]);
  end
endmodule

// File: rtl/cs_mult_ctrl.sv
module cs_mult_ctrl
  import cs_mult_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load_o,
  output logic step_o,
  output logic resolve_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = $clog2(N + 1);

  phase_t        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (ph_q)
      PH_IDLE: begin
        if (start) begin
          ph_d  = PH_STEP;
          cnt_d = CW'(N - 1);
        end
      end
      PH_STEP: begin
        if (cnt_q == '0) ph_d = PH_RESOLVE;
        else             cnt_d = cnt_q - 1'b1;
      end
      PH_RESOLVE: begin
        ph_d   = PH_IDLE;
        done_d = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign load_o    = (ph_q == PH_IDLE) && start;
  assign step_o    = (ph_q == PH_STEP);
  assign resolve_o = (ph_q == PH_RESOLVE);
  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = done_q;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_resolve_after_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RESOLVE) |-> $past(ph_q == PH_STEP));
  p_done_after_resolve_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(ph_q == PH_RESOLVE));
  p_busy_start_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph_q == PH_STEP) && cnt_q != '0 && start) |=> (ph_q == PH_STEP));
endmodule

// File: rtl/cs_seq_mult.sv
module cs_seq_mult #(
  parameter int N = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N-1:0]   multiplicand,
  input  logic [N-1:0]   multiplier,
  output logic [2*N-1:0] product,
  output logic           done
);
  localparam int CSW = N - 1;

  logic load, step, resolve, busy;

  logic [N-1:0]   sum_q, sum_d;
  logic [CSW-1:0] cs_q,  cs_d;
  logic [N-1:0]   mq_q,  mq_d;
  logic [N-1:0]   mc_q,  mc_d;
  logic [N-1:0]   pp, row_sum, row_cry;

  cs_mult_ctrl #(.N(N)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .load_o   (load),
    .step_o   (step),
    .resolve_o(resolve),
    .busy_o   (busy),
    .done_o   (done)
  );

  assign pp = mq_q[0] ? mc_q : '0;

  cs_adder_row #(.W(N)) u_row (
    .in_a (sum_q),
    .in_b ({1'b0, cs_q}),
    .in_c (pp),
    .sum_o(row_sum),
    .cry_o(row_cry)
  );

  // Shift step: the row carry at weight i+1 lands at weight i after the shift.
  // The topmost carry fills the vacated sum MSB, so the carry word needs N-1 bits.
  always_comb begin
    sum_d = sum_q;
    cs_d  = cs_q;
    mq_d  = mq_q;
    mc_d  = mc_q;
    if (load) begin
      sum_d = '0;
      cs_d  = '0;
      mq_d  = multiplier;
      mc_d  = multiplicand;
    end else if (step) begin
      sum_d = {row_cry[N-1], row_sum[N-1:1]};
      cs_d  = row_cry[CSW-1:0];
      mq_d  = {row_sum[0], mq_q[N-1:1]};
    end else if (resolve) begin
      sum_d = sum_q + {1'b0, cs_q};
      cs_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      cs_q  <= '0;
      mq_q  <= '0;
      mc_q  <= '0;
    end else begin
      if (load || step || resolve) begin
        sum_q <= sum_d;
        cs_q  <= cs_d;
        mq_q  <= mq_d;
      end
      if (load) mc_q <= mc_d;
    end
  end

  assign product = {sum_q, mq_q};

  p_carry_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_q == '0));
  p_operand_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(mc_q));
  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
  p_no_resolve_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    resolve |-> ({1'b0, sum_q} + {2'b00, cs_q}) < (1 << N));
endmodule

// File: tb/cs_seq_mult_test.sv
module cs_seq_mult_test;
  localparam int W = 6;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [W-1:0]   mcand = '0;
  logic [W-1:0]   mplier = '0;
  logic [2*W-1:0] product;
  logic           done;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;

  cs_seq_mult #(.N(W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .multiplicand(mcand),
    .multiplier  (mplier),
    .product     (product),
    .done        (done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    return (2*W)'(a) * (2*W)'(b);
  endfunction

  // Drives one start at a negedge; returns the number of edges, counted after
  // the accepting edge, up to the first negedge where done is high.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, output int k);
    mcand  = a;
    mplier = b;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < 4*W);
  endtask

  initial begin
    int k;
    logic [2*W-1:0] held;
    repeat (3) @(negedge clk);
    // R5 reset state
    check("R5 product at reset", 64'(product), 64'd0);
    check("R5 done at reset", 64'(done), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 corner operands
    run_op('0, '1, k);
    check("R7 zero x ones", 64'(product), 64'd0);
    run_op(W'(1), W'(45), k);
    check("R7 one x value", 64'(product), 64'(ref_mul(W'(1), W'(45))));
    run_op(W'(37), W'(1), k);
    check("R7 value x one", 64'(product), 64'(ref_mul(W'(37), W'(1))));
    run_op('1, '1, k);
    check("R7 ones x ones", 64'(product), 64'(ref_mul('1, '1)));

    // R2 done timing and width of pulse
    run_op(W'(21), W'(42), k);
    check("R2 done edge count", 64'(k), 64'(W + 1));
    @(negedge clk);
    check("R2 done single cycle", 64'(done), 64'd0);

    // R6 hold while idle
    held = product;
    repeat (5) @(negedge clk);
    check("R6 product held while idle", 64'(product), 64'(held));

    // R3 start during busy is ignored
    mcand = W'(13); mplier = W'(27); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mcand = W'(50); mplier = W'(9); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 2;
    do begin
      @(negedge clk);
      k++;
    end while (!done && k < 4*W);
    check("R3 result of first operands", 64'(product), 64'(ref_mul(W'(13), W'(27))));
    check("R3 done timing unchanged", 64'(k), 64'(W + 1));

    // R6 start accepted in the done cycle
    run_op(W'(19), W'(23), k);
    run_op(W'(33), W'(11), k);
    check("R6 back-to-back result", 64'(product), 64'(ref_mul(W'(33), W'(11))));
    check("R6 back-to-back timing", 64'(k), 64'(W + 1));

    // R1, R4, R2 exhaustive sweep
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        logic [2*W-1:0] e;
        run_op(W'(a), W'(b), k);
        e = ref_mul(W'(a), W'(b));
        check("R1 full product", 64'(product), 64'(e));
        check("R4 low half", 64'(product[W-1:0]), 64'(e[W-1:0]));
        if (k != W + 1) check("R2 sweep timing", 64'(k), 64'(W + 1));
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule